// File: doc/BRIEF.md
# Region-Selected Bus Wait-State Generator

This block stretches microcontroller bus cycles by a number of wait states chosen from the upper byte of the latched address. A small table of address regions, each with a wait count from 0 to 7, sits inside the block. When a bus cycle starts, a 3-bit state machine on the rising clock edge drives an active-low wait request. The machine passes through a run of hold states and then a release state that always drops the request.

A second stage, clocked on the falling edge, turns that request into the active-low ready-hold output that the processor samples. This output stays valid up to the falling edge. It also goes low at once while the address strobe is high and a wait is requested. An external requester can pull it low at any time. Cycle start is marked by a stretched strobe, which stays high past the next rising edge. No cycle starts while the bus is granted away, which is shown by the active-low hold-acknowledge input being low. Chip enables and the memories themselves lie outside this block.

Top module: `ws_gen`

## Requirements
- R1: While `rst_n` is low, and after its release until a cycle starts, the machine rests in its idle state. `ready_n` is high, provided `ale` and `usr_wait_req` are low.
- R2: A cycle starts on a rising edge only when `stale` is 1, `hold_ack_n` is 1 and the region count of `addr_hi` is non-zero. With `hold_ack_n` at 0, no waits are produced and `wait_n` stays 1.
- R3: In the idle state, `wait_n` is 0 combinationally exactly when `stale` is 1, `hold_ack_n` is 1 and the region count is non-zero. With a count of 0, `wait_n` stays 1 and the state does not change.
- R4: For a count of 1, the cycle after the start cycle is the release state, where `wait_n` is 1 whatever the inputs. The release state always returns to idle on the next edge.
- R5: For a count n from 2 to 7, `wait_n` is 0 for exactly n consecutive clock cycles, counting the start cycle. It is then 1 for one release cycle.
- R6: A falling-edge flip-flop captures `wait_n`, and `ready_n` is 0 while that flip-flop holds 0. `ready_n` is also 0 at once whenever `ale` is 1 and `wait_n` is 0.
- R7: `usr_wait_req` = 1 forces `ready_n` to 0, independently of the state machine.
- R8: The default table is as follows. Upper byte 00h gives 1 wait, 1Dh gives 1, 1Eh gives 2, and 80h–BFh gives 1. Every other byte gives 0. Where regions overlap, the lowest table index wins.
- R9: For each bus cycle, the number of falling edges after which `ready_n` reads 0 equals that region's table count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; state on rising edge, ready stage on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_hi | input | 8 | Upper byte of the latched bus address |
| ale | input | 1 | Address strobe, active high |
| stale | input | 1 | Stretched address strobe marking cycle start, active high |
| hold_ack_n | input | 1 | Hold acknowledge, active low; 0 blocks cycle start |
| usr_wait_req | input | 1 | External wait request, active high |
| wait_n | output | 1 | Rising-edge wait request, active low |
| ready_n | output | 1 | Falling-edge ready-hold to the processor, active low |

## Verification
The bench builds the block with six regions. The first four equal the default table, and two more are added: C0h–C3h with 7 waits and 40h with 4. These bring within reach the maximum hold run, a mid-length run, and the 1- and 2-wait paths. Each cycle a behavioural model predicts both outputs, covering cycles blocked by hold-acknowledge, zero-wait regions and forced external waits. Per bus cycle, the count of falling edges with `ready_n` low is compared with the table value.

// File: rtl/ws_pkg.sv
package ws_pkg;
  localparam int WS_W = 3;
  typedef logic [WS_W-1:0] ws_state_t;
  localparam ws_state_t ST_IDLE   = 3'd0;
  localparam ws_state_t ST_REMOVE = 3'd1;
  localparam ws_state_t ST_HOLD2  = 3'd2;
endpackage

// File: rtl/ws_region_lut.sv
module ws_region_lut #(
  parameter int NREG = 4,
  parameter logic [NREG*8-1:0] REG_LO  = {8'h80, 8'h1E, 8'h1D, 8'h00},
  parameter logic [NREG*8-1:0] REG_HI  = {8'hBF, 8'h1E, 8'h1D, 8'h00},
  parameter logic [NREG*3-1:0] REG_CNT = {3'd1, 3'd2, 3'd1, 3'd1}
) (
  input  logic [7:0] addr_hi,
  output logic [2:0] need
);
  logic [NREG-1:0] hit;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [7:0] LO   = REG_LO[g*8 +: 8];
    localparam logic [7:0] SPAN = REG_HI[g*8 +: 8] - REG_LO[g*8 +: 8];
    logic [7:0] off;
    assign off    = addr_hi - LO;
    assign hit[g] = (off <= SPAN);
  end

  // lowest index has priority
  always_comb begin
    need = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (hit[i]) need = REG_CNT[i*3 +: 3];
    end
  end
endmodule

// File: rtl/ws_fsm.sv
module ws_fsm
  import ws_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic [2:0] need,
  input  logic      stale,
  input  logic      hold_ack_n,
  output logic      wait_n
);
  ws_state_t state, nxt;
  logic [2:0] tgt;
  logic       start;

  assign start = stale & hold_ack_n & (need != 3'd0);

  always_comb begin
    nxt    = state;
    wait_n = 1'b1;
    case (state)
      ST_IDLE: begin
        wait_n = ~start;
        if (start) nxt = (need == 3'd1) ? ST_REMOVE : ST_HOLD2;
      end
      ST_REMOVE: begin
        wait_n = 1'b1;
        nxt    = ST_IDLE;
      end
      default: begin
        wait_n = 1'b0;
        nxt    = (state == tgt) ? ST_REMOVE : state + 3'd1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      tgt   <= '0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && start) tgt <= need;
    end
  end

  a_r2_hold_ack_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !hold_ack_n) |=> state == ST_IDLE);
  a_r3_zero_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && need == 3'd0) |=> state == ST_IDLE);
  a_r4_single_to_remove: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && stale && hold_ack_n && need == 3'd1) |=> state == ST_REMOVE);
  a_r4_remove_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REMOVE) |-> wait_n);
  a_r4_remove_exits: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REMOVE) |=> state == ST_IDLE);
  a_r5_hold_asserts: assert property (@(posedge clk) disable iff (!rst_n)
    (state >= ST_HOLD2) |-> !wait_n);
  a_r5_hold_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (state >= ST_HOLD2) |-> state <= tgt);
endmodule

// File: rtl/ws_ready_sync.sv
module ws_ready_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_n,
  input  logic ale,
  input  logic usr_wait_req,
  output logic ready_n
);
  logic q_n;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) q_n <= 1'b1;
    else        q_n <= wait_n;
  end

  assign ready_n = q_n & ~(ale & ~wait_n) & ~usr_wait_req;

  a_r6_capture_holds: assert property (@(negedge clk) disable iff (!rst_n)
    !wait_n |=> !ready_n);
  a_r7_user_forces: assert property (@(posedge clk) disable iff (!rst_n)
    usr_wait_req |-> !ready_n);
endmodule

// File: rtl/ws_gen.sv
module ws_gen #(
  parameter int NREG = 4,
  parameter logic [NREG*8-1:0] REG_LO  = {8'h80, 8'h1E, 8'h1D, 8'h00},
  parameter logic [NREG*8-1:0] REG_HI  = {8'hBF, 8'h1E, 8'h1D, 8'h00},
  parameter logic [NREG*3-1:0] REG_CNT = {3'd1, 3'd2, 3'd1, 3'd1}
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] addr_hi,
  input  logic       ale,
  input  logic       stale,
  input  logic       hold_ack_n,
  input  logic       usr_wait_req,
  output logic       wait_n,
  output logic       ready_n
);
  logic [2:0] need;

  ws_region_lut #(.NREG(NREG), .REG_LO(REG_LO), .REG_HI(REG_HI), .REG_CNT(REG_CNT))
    u_lut (.addr_hi(addr_hi), .need(need));

  ws_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .need(need), .stale(stale),
    .hold_ack_n(hold_ack_n), .wait_n(wait_n)
  );

  ws_ready_sync u_sync (
    .clk(clk), .rst_n(rst_n), .wait_n(wait_n), .ale(ale),
    .usr_wait_req(usr_wait_req), .ready_n(ready_n)
  );

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) && !ale && !usr_wait_req |-> ready_n);
endmodule

// File: tb/ws_gen_bench.sv
module ws_gen_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [7:0] addr_hi = 8'h01;
  logic       ale = 1'b0, stale = 1'b0, hold_ack_n = 1'b1, usr_wait_req = 1'b0;
  logic       wait_n, ready_n;

  ws_gen #(
    .NREG(6),
    .REG_LO ({8'h40, 8'hC0, 8'h80, 8'h1E, 8'h1D, 8'h00}),
    .REG_HI ({8'h40, 8'hC3, 8'hBF, 8'h1E, 8'h1D, 8'h00}),
    .REG_CNT({3'd4, 3'd7, 3'd1, 3'd2, 3'd1, 3'd1})
  ) u_ws_gen (
    .clk(clk), .rst_n(rst_n), .addr_hi(addr_hi), .ale(ale), .stale(stale),
    .hold_ack_n(hold_ack_n), .usr_wait_req(usr_wait_req),
    .wait_n(wait_n), .ready_n(ready_n)
  );

  int    vecs = 0, miss = 0;
  string req = "R1";
  int    phase = 0;     // 0 idle, >0 hold cycles left, -1 release
  logic  qm = 1'b1;
  bit    done = 0;

  function automatic int need_of(logic [7:0] a);
    if (a == 8'h00 || a == 8'h1D)   return 1;
    if (a == 8'h1E)                 return 2;
    if (a >= 8'h80 && a <= 8'hBF)   return 1;
    if (a >= 8'hC0 && a <= 8'hC3)   return 7;
    if (a == 8'h40)                 return 4;
    return 0;
  endfunction

  function automatic logic exp_wait();
    if (phase == 0) return !(stale && hold_ack_n && need_of(addr_hi) > 0);
    if (phase > 0)  return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase = 0;
    else if (phase == 0) begin
      if (stale && hold_ack_n && need_of(addr_hi) > 0)
        phase = (need_of(addr_hi) == 1) ? -1 : need_of(addr_hi) - 1;
    end else if (phase > 0) phase = (phase == 1) ? -1 : phase - 1;
    else phase = 0;
  end

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) qm = 1'b1;
    else        qm = exp_wait();
  end

  task automatic chk(string what, logic act, logic exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n && !done) begin
      #4 chk("wait_n", wait_n, exp_wait());
      #4 chk("ready_n", ready_n, qm & ~(ale & ~exp_wait()) & ~usr_wait_req);
    end
  end

  // one bus cycle; returns falling edges with ready_n low
  task automatic bus(logic [7:0] a, logic hla, output int cnt);
    cnt = 0;
    @(posedge clk); #1;
    addr_hi = a; stale = 1'b1; ale = 1'b1; hold_ack_n = hla;
    #7 if (ready_n === 1'b0) cnt++;
    for (int k = 0; k < 11; k++) begin
      @(posedge clk); #1;
      stale = 1'b0; ale = 1'b0;
      #7 if (ready_n === 1'b0) cnt++;
    end
    @(posedge clk); #1;
    addr_hi = 8'h01; hold_ack_n = 1'b1;
  endtask

  task automatic region(logic [7:0] a, string tag);
    int c;
    req = tag;
    bus(a, 1'b1, c);
    vecs++;
    if (c != need_of(a)) begin
      miss++;
      $display("FAIL R9 %s addr=%h count actual=%0d expected=%0d", tag, a, c, need_of(a));
    end
  endtask

  initial begin
    int c;
    repeat (3) @(posedge clk);
    #3 req = "R1";
    chk("wait_n in reset", wait_n, 1'b1);
    chk("ready_n in reset", ready_n, 1'b1);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #6 chk("ready_n after reset R1", ready_n, 1'b1);

    region(8'h00, "R8 R4 1-wait low region");
    region(8'h1D, "R8 R4 1-wait region");
    region(8'h1E, "R8 R5 2-wait region");
    region(8'h80, "R8 R4 region base");
    region(8'hBF, "R8 R4 region top");
    region(8'h7F, "R8 R3 zero-wait");
    region(8'h01, "R3 zero-wait");
    region(8'hC0, "R5 seven waits");
    region(8'hC3, "R5 seven waits top");
    region(8'h40, "R5 four waits");
    region(8'h1E, "R6 repeat 2-wait");

    req = "R2 hold_ack blocks start";
    bus(8'hC1, 1'b0, c);
    vecs++;
    if (c != 0) begin
      miss++;
      $display("FAIL R2 count actual=%0d expected=0", c);
    end

    req = "R7 user request";
    @(posedge clk); #1 usr_wait_req = 1'b1;
    repeat (3) @(posedge clk);
    #1 usr_wait_req = 1'b0;
    repeat (3) @(posedge clk);

    req = "R7 user during cycle";
    @(posedge clk); #1 usr_wait_req = 1'b1;
    bus(8'h1E, 1'b1, c);
    usr_wait_req = 1'b0;
    repeat (3) @(posedge clk);

    done = 1;
    #1 $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    miss++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule